// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a clocked model of a single-port synchronous burst SRAM with byte-lane writes. On every rising clock edge it samples three chip enables, a sleep input, two address strobes, a burst-advance input, the write-enable inputs and an external address. From these it decodes the cycle: sleep, deselect, burst start, burst step, burst hold, or idle. It then reads or writes an internal array at the resulting address.

One strobe belongs to the processor side. While the first enable is low, this strobe always starts a read. The other strobe belongs to the controller side and can start either a read or a write. When both strobes are inactive, the burst-advance input chooses between stepping a two-bit counter and holding the current address. The counter wraps within an aligned group of four words. Read data is registered. The output-drive enable combines the registered read flag with an asynchronous output-enable input.

Top module: `sbs_ctrl`

## Requirements
- R1: After reset `rdata` is all zeros and `rdata_oe` is low.
- R2: While `sleep` is high at an edge, no array access happens and `rdata_oe` is low after that edge. A running burst is ended.
- R3: A deselect cycle ends the burst, writes nothing and leaves `rdata_oe` low. A deselect cycle is a strobe (`stb_cpu_n` low with `ce_a_n` low, or `stb_ctl_n` low) while the chip is not selected. The chip is selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0.
- R4: `stb_cpu_n` low with `ce_a_n` low and the chip selected starts a read at `addr`, whatever `gw_n`, `bwe_n` and `lane_n` are.
- R5: `stb_cpu_n` is ignored while `ce_a_n` is high. With `stb_ctl_n` also high, the cycle is a burst step or hold.
- R6: `stb_ctl_n` low (and the processor-side strobe not taking effect) with the chip selected starts a burst at `addr`. The decoded write of R9 chooses between a write and a read.
- R7: With both strobes inactive, a live burst and `adv_n` low, the low two address bits increment modulo 4. The upper bits stay unchanged, and the access is made at the new address.
- R8: With both strobes inactive, a live burst and `adv_n` high, the access reuses the current address.
- R9: A write is decoded when `gw_n`=0, which writes all four lanes. It is also decoded when `bwe_n`=0 with some `lane_n[i]`=0, which writes exactly those lanes. Otherwise the cycle is a read. Lane i is `wdata[9i+8:9i]`, including its parity bit.
- R10: Read data appears on `rdata` right after the edge that decodes the read. `rdata_oe` is high only after a read cycle while `oe_n` is low, and it follows `oe_n` without waiting for a clock. After a write cycle it stays low.
- R11: A step or hold cycle with no live burst (after reset, a deselect or sleep) does nothing and leaves `rdata_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a_n | input | 1 | Chip enable A, active low, also gates the processor strobe |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| sleep | input | 1 | Snooze request |
| stb_cpu_n | input | 1 | Processor-side address strobe, active low |
| stb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Per-lane write selects, active low |
| addr | input | 8 | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | Output drive enable for rdata |

## Verification
The array is first filled through full-word controller-strobe writes, so every later read has a known expected word. Directed sequences then separate the two strobes. A processor strobe with global write low must read and leave memory untouched. The same strobe with the first enable high must act as a step. A burst started at a group's last word shows whether the counter wraps inside its group or carries into the upper bits. Byte-write patterns with no lanes, some lanes and all lanes selected separate the read, partial-write and full-write decodes. A long random run then mixes sleep, deselects and steps with no live burst against a bench model of the array and burst state.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE  = 3'd0,
      CYC_DESEL = 3'd1,
      CYC_SLEEP = 3'd2,
      CYC_START = 3'd3,
      CYC_NEXT  = 3'd4,
      CYC_HOLD  = 3'd5
   } cyc_e;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
   import sbs_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             ce_a_n,
   input  logic             ce_b,
   input  logic             ce_c_n,
   input  logic             sleep,
   input  logic             stb_cpu_n,
   input  logic             stb_ctl_n,
   input  logic             adv_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] lane_n,
   input  logic             live,
   output cyc_e             cyc,
   output logic             do_rd,
   output logic             do_wr,
   output logic [LANES-1:0] lane_we
);
   logic             sel;
   logic             cpu_hit;
   logic [LANES-1:0] mask;
   logic             wr_req;

   assign sel     = !ce_a_n && ce_b && !ce_c_n;
   assign cpu_hit = !stb_cpu_n && !ce_a_n;

   always_comb begin
      if (!gw_n)       mask = '1;
      else if (!bwe_n) mask = ~lane_n;
      else             mask = '0;
   end
   assign wr_req = |mask;

   always_comb begin
      cyc   = CYC_IDLE;
      do_rd = 1'b0;
      do_wr = 1'b0;
      if (sleep) begin
         cyc = CYC_SLEEP;
      end else if (cpu_hit) begin
         cyc   = sel ? CYC_START : CYC_DESEL;
         do_rd = sel;
      end else if (!stb_ctl_n) begin
         cyc   = sel ? CYC_START : CYC_DESEL;
         do_wr = sel && wr_req;
         do_rd = sel && !wr_req;
      end else if (live) begin
         cyc   = adv_n ? CYC_HOLD : CYC_NEXT;
         do_wr = wr_req;
         do_rd = !wr_req;
      end
   end

   assign lane_we = do_wr ? mask : '0;

   always_comb begin
      a_r9_rd_wr_excl : assert (!(do_rd && do_wr));
   end
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
   import sbs_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_e              cyc,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              live
);
   logic [ADDR_W-1:0]  cur_addr;
   logic [BURST_W-1:0] step_lo;

   assign step_lo = cur_addr[BURST_W-1:0] + BURST_W'(1);

   generate
      if (BURST_W == ADDR_W) begin : g_whole
         always_comb begin
            case (cyc)
               CYC_START: acc_addr = ext_addr;
               CYC_NEXT:  acc_addr = step_lo;
               default:   acc_addr = cur_addr;
            endcase
         end
      end else begin : g_split
         always_comb begin
            case (cyc)
               CYC_START: acc_addr = ext_addr;
               CYC_NEXT:  acc_addr = {cur_addr[ADDR_W-1:BURST_W], step_lo};
               default:   acc_addr = cur_addr;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         live     <= 1'b0;
      end else begin
         cur_addr <= acc_addr;
         if (cyc == CYC_START)
            live <= 1'b1;
         else if (cyc == CYC_DESEL || cyc == CYC_SLEEP)
            live <= 1'b0;
      end
   end

   a_r8_hold_addr : assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_HOLD) |=> (cur_addr == $past(cur_addr)));

   a_r7_step_low : assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_NEXT) |=>
         (cur_addr[BURST_W-1:0] == BURST_W'($past(cur_addr[BURST_W-1:0]) + BURST_W'(1))));

   a_r3_desel_ends : assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == CYC_DESEL) |=> !live);
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [LANES-1:0]        lane_we,
   input  logic                    rd_en,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] store [DEPTH];

         always_ff @(posedge clk) begin
            if (lane_we[g])
               store[addr] <= wdata[g*LANE_W +: LANE_W];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rdata[g*LANE_W +: LANE_W] <= '0;
            else if (rd_en)
               rdata[g*LANE_W +: LANE_W] <= store[addr];
         end
      end
   endgenerate
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
   import sbs_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce_a_n,
   input  logic                    ce_b,
   input  logic                    ce_c_n,
   input  logic                    sleep,
   input  logic                    stb_cpu_n,
   input  logic                    stb_ctl_n,
   input  logic                    adv_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        lane_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    oe_n,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);
   localparam int DW = LANES * LANE_W;

   initial begin : p_param_chk
      a_par_burst : assert (BURST_W >= 1 && BURST_W <= ADDR_W)
         else $error("BURST_W out of range");
      a_par_lanes : assert (LANES >= 1 && LANE_W >= 1 && DW <= 1024)
         else $error("lane geometry out of range");
      a_par_depth : assert (ADDR_W >= 1 && ADDR_W <= 12)
         else $error("ADDR_W out of range");
   end

   cyc_e              cyc;
   logic              do_rd;
   logic              do_wr;
   logic [LANES-1:0]  lane_we;
   logic              live;
   logic [ADDR_W-1:0] acc_addr;
   logic              rd_valid;

   sbs_decode #(.LANES(LANES)) u_dec (
      .ce_a_n   (ce_a_n),
      .ce_b     (ce_b),
      .ce_c_n   (ce_c_n),
      .sleep    (sleep),
      .stb_cpu_n(stb_cpu_n),
      .stb_ctl_n(stb_ctl_n),
      .adv_n    (adv_n),
      .gw_n     (gw_n),
      .bwe_n    (bwe_n),
      .lane_n   (lane_n),
      .live     (live),
      .cyc      (cyc),
      .do_rd    (do_rd),
      .do_wr    (do_wr),
      .lane_we  (lane_we)
   );

   sbs_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cyc     (cyc),
      .ext_addr(addr),
      .acc_addr(acc_addr),
      .live    (live)
   );

   sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (acc_addr),
      .wdata  (wdata),
      .lane_we(lane_we),
      .rd_en  (do_rd),
      .rdata  (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= do_rd;
   end

   assign rdata_oe = rd_valid && !oe_n;

   a_r2_sleep_float : assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !rdata_oe);

   a_r2_sleep_no_write : assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (lane_we == '0));

   a_r4_cpu_reads : assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !stb_cpu_n && !ce_a_n) |-> (lane_we == '0));

   a_r10_write_masks_oe : assert property (@(posedge clk) disable iff (!rst_n)
      do_wr |=> !rdata_oe);

   a_r9_global_all_lanes : assert property (@(posedge clk) disable iff (!rst_n)
      (do_wr && !gw_n) |-> ($countones(lane_we) == LANES));

   a_r11_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !sleep && stb_ctl_n && (stb_cpu_n || ce_a_n)) |=> !rdata_oe);
endmodule

// File: tb/sim_sbs_ctrl.sv
`timescale 1ns/1ps
module sim_sbs_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ce_a_n, ce_b, ce_c_n, sleep;
   logic        stb_cpu_n, stb_ctl_n, adv_n, gw_n, bwe_n;
   logic [3:0]  lane_n;
   logic [7:0]  addr;
   logic [35:0] wdata;
   logic        oe_n;
   logic [35:0] rdata;
   logic        rdata_oe;

   int n_checks = 0;
   int n_errors = 0;

   logic [35:0] mdl [256];
   logic        m_live;
   logic [7:0]  m_cur;
   logic        m_rd;
   logic [35:0] m_q;
   string       m_tag;

   always #10 clk = ~clk;

   sbs_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
      .sleep(sleep), .stb_cpu_n(stb_cpu_n), .stb_ctl_n(stb_ctl_n), .adv_n(adv_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n), .addr(addr), .wdata(wdata),
      .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] lane_mask(input logic g, input logic b, input logic [3:0] l);
      if (!g) return 4'hF;
      if (!b) return ~l;
      return 4'h0;
   endfunction

   task automatic access();
      logic [3:0] m;
      m = lane_mask(gw_n, bwe_n, lane_n);
      if (m != 0) begin
         for (int i = 0; i < 4; i++)
            if (m[i]) mdl[m_cur][i*9 +: 9] = wdata[i*9 +: 9];
         m_tag = {m_tag, "/R9"};
      end else begin
         m_rd = 1'b1;
         m_q  = mdl[m_cur];
      end
   endtask

   task automatic model_edge();
      logic sel;
      sel  = !ce_a_n && ce_b && !ce_c_n;
      m_rd = 1'b0;
      if (sleep) begin
         m_live = 1'b0; m_tag = "R2";
      end else if (!stb_cpu_n && !ce_a_n) begin
         if (sel) begin
            m_live = 1'b1; m_cur = addr; m_rd = 1'b1; m_q = mdl[m_cur]; m_tag = "R4";
         end else begin
            m_live = 1'b0; m_tag = "R3";
         end
      end else if (!stb_ctl_n) begin
         if (sel) begin
            m_live = 1'b1; m_cur = addr; m_tag = ce_a_n ? "R5/R6" : "R6"; access();
         end else begin
            m_live = 1'b0; m_tag = "R3";
         end
      end else if (m_live) begin
         if (!adv_n) begin
            m_cur[1:0] = m_cur[1:0] + 2'd1; m_tag = "R7";
         end else begin
            m_tag = "R8";
         end
         if (!stb_cpu_n) m_tag = {m_tag, "/R5"};
         access();
      end else begin
         m_tag = "R11";
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      #2;
      check({m_tag, "/R10 oe"}, {35'd0, rdata_oe}, {35'd0, m_rd && !oe_n});
      if (m_rd) check({m_tag, " data"}, rdata, m_q);
   endtask

   task automatic idle_in();
      sleep = 0; ce_a_n = 0; ce_b = 1; ce_c_n = 0;
      stb_cpu_n = 1; stb_ctl_n = 1; adv_n = 1;
      gw_n = 1; bwe_n = 1; lane_n = 4'hF; addr = 0; wdata = 0; oe_n = 0;
   endtask

   task automatic rand_in();
      sleep     = ($urandom % 16) == 0;
      ce_a_n    = ($urandom % 8) == 0;
      ce_b      = ($urandom % 8) != 0;
      ce_c_n    = ($urandom % 8) == 0;
      stb_cpu_n = ($urandom % 3) != 0;
      stb_ctl_n = ($urandom % 3) != 0;
      adv_n     = 1'($urandom % 2);
      gw_n      = ($urandom % 4) != 0;
      bwe_n     = 1'($urandom % 2);
      lane_n    = 4'($urandom);
      addr      = 8'($urandom);
      wdata     = {4'($urandom), 32'($urandom)};
      oe_n      = ($urandom % 4) == 0;
   endtask

   initial begin
      #(20 * 150000);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      m_live = 0; m_cur = 0; m_rd = 0; m_q = 0; m_tag = "";
      idle_in();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #2;
      check("R1 rdata", rdata, 36'd0);
      check("R1 oe", {35'd0, rdata_oe}, 36'd0);
      rst_n = 1;

      // fill the array with full-word writes
      for (int a = 0; a < 256; a++) begin
         stb_ctl_n = 0; gw_n = 0; addr = 8'(a);
         wdata = {4'(a), 8'(a ^ 8'h5A), 8'(a), 8'(~a), 8'(a + 3)};
         tick();
      end
      idle_in();

      // R4: processor strobe reads even with global write low
      stb_cpu_n = 0; gw_n = 0; addr = 8'h05; wdata = '1; tick();
      idle_in(); stb_cpu_n = 0; addr = 8'h05; tick();

      // R7: wrap inside group, starting at last word
      idle_in(); stb_ctl_n = 0; addr = 8'h13; tick();
      idle_in(); adv_n = 0; tick(); tick(); tick();
      // R8: hold
      idle_in(); tick();
      // R5: processor strobe ignored while ce_a_n high
      idle_in(); ce_a_n = 1; stb_cpu_n = 0; adv_n = 0; tick();

      // R9: byte-write enable with no lanes selected is a read
      idle_in(); stb_ctl_n = 0; bwe_n = 0; lane_n = 4'hF; addr = 8'h20; tick();
      idle_in(); stb_ctl_n = 0; bwe_n = 0; lane_n = 4'b1010; addr = 8'h20;
      wdata = 36'hABCDE1234; tick();
      idle_in(); stb_cpu_n = 0; addr = 8'h20; tick();

      // R3 then R11
      idle_in(); stb_ctl_n = 0; ce_b = 0; gw_n = 0; addr = 8'h30; wdata = 0; tick();
      idle_in(); adv_n = 0; gw_n = 0; tick();
      idle_in(); stb_cpu_n = 0; addr = 8'h30; tick();

      // R2: sleep blocks a write
      idle_in(); sleep = 1; stb_ctl_n = 0; gw_n = 0; addr = 8'h40; wdata = 0; tick();
      idle_in(); stb_cpu_n = 0; addr = 8'h40; tick();

      // R10: output enable acts without a clock
      oe_n = 1; #1;
      check("R10 async off", {35'd0, rdata_oe}, 36'd0);
      oe_n = 0; #1;
      check("R10 async on", {35'd0, rdata_oe}, {35'd0, m_rd});

      for (int k = 0; k < 4000; k++) begin
         rand_in();
         tick();
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule